// File: doc/BRIEF.md
# Stop Mode Wake Controller

This block governs the deepest low-power state of a processor. It holds the CPU clock configuration (source select and divider code). Software enters the stop state by writing 1 to a stop-request bit. While stopped, every oscillator enable is dropped and the CPU clock gate is closed.

Three events end the stop state. Hardware reset is asynchronous and returns the block to its default configuration. A non-maskable interrupt always wakes the block. A peripheral interrupt request wakes it only when three conditions hold: its priority level is non-zero, that level is strictly above the processor priority, and the global interrupt enable is set.

After a non-maskable or peripheral wake, the clock source in use before entry is kept. The divider is then forced to suit that source: undivided for the sub clock, divide-by-8 for the main clock and for the on-chip oscillator. The CPU clock stays gated until two things have happened: the chosen oscillator reports ready, and that ready has then held for a fixed run of reference cycles. Only then does the clock-on output rise. The interrupt logic uses that output as its signal that a pending request may now be serviced.

Top module: `stopw_ctrl`

## Requirements
- R1: After hardware reset the clock source is main (code 00), the divider code is 3 (divide by 8), the stop bit is 0, the clock-on output is 0 and only the main oscillator enable (osc_en_o bit 0) is set.
- R2: In the running state, a stop write with data 1 takes effect on the next cycle. At that point the stop bit is 1, clock-on is 0 and all three oscillator enables are 0. A stop write with data 0 has no effect.
- R3: A non-maskable interrupt ends the stop state whatever the interrupt enable and the priority levels. The stop bit reads 0 one cycle after the request is seen.
- R4: A peripheral request ends the stop state only when all three of these hold: its 3-bit level (request i uses irq_lvl_i bits 3i+2..3i) is strictly greater than cpu_lvl_i, that level is not 000, and ie_i is 1.
- R5: While no wake source qualifies, the block stays stopped with clock-on 0 and the stop bit 1.
- R6: Wake from a stop entered on the sub clock (code 01) keeps source 01 and sets the divider code to 0 (undivided). The sub oscillator enable is osc_en_o bit 1.
- R7: Wake from a stop entered on the main clock (00) or the on-chip oscillator (code 10, enable osc_en_o bit 2) keeps the source and sets the divider code to 3.
- R8: After reset or a wake, clock-on rises only after the selected oscillator's ready has been high on STAB_CYC (16) consecutive clock edges. A drop in ready restarts that count.
- R9: A configuration write while running stores the source and divider code. A write with source code 11 is ignored. Configuration writes while stopped or waking are ignored.
- R10: A hardware reset during stop restores the defaults of R1, not the values held at stop entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cfg_wr_i | input | 1 | Clock configuration write strobe |
| cfg_src_i | input | 2 | Source code to write (00 main, 01 sub, 10 on-chip) |
| cfg_div_i | input | 3 | Divider code to write (0 = /1, 3 = /8) |
| stop_wr_i | input | 1 | Stop-request bit write strobe |
| stop_wdata_i | input | 1 | Value written to the stop-request bit |
| nmi_i | input | 1 | Non-maskable interrupt request |
| irq_req_i | input | NUM_IRQ | Peripheral interrupt requests |
| irq_lvl_i | input | NUM_IRQ*LVL_W | Packed priority levels, 3 bits per request |
| cpu_lvl_i | input | LVL_W | Current processor priority level |
| ie_i | input | 1 | Global interrupt enable flag |
| osc_rdy_i | input | 3 | Oscillator ready: main, sub, on-chip |
| osc_en_o | output | 3 | Oscillator enable: main, sub, on-chip |
| clk_src_o | output | 2 | CPU clock source code |
| clk_div_o | output | 3 | CPU clock divider code |
| stop_bit_o | output | 1 | Stop-request bit readback |
| cpu_clk_on_o | output | 1 | CPU clock gate open; interrupts may be serviced |

## Verification
A stuck state register shows up at the ports within one cycle of the triggering event. The stop bit fails to clear after a wake, or the oscillator enables stay non-zero after a stop write. A wrong qualification of peripheral levels appears one cycle after the request, as the stop bit holding or clearing against the expected result. A stabilisation counter that is off by even one edge moves the rising edge of clock-on away from exactly sixteen ready edges after the wake. A divider chosen for the wrong source is visible on clk_div_o from the first waking cycle.

// File: rtl/stopw_pkg.sv
package stopw_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WAKE = 2'd2
    } stop_st_e;

    localparam int SRC_W   = 2;
    localparam int DIV_W   = 3;
    localparam int NUM_OSC = 3;

    localparam logic [SRC_W-1:0] SRC_MAIN = 2'd0;
    localparam logic [SRC_W-1:0] SRC_SUB  = 2'd1;
    localparam logic [SRC_W-1:0] SRC_OCO  = 2'd2;
    localparam logic [SRC_W-1:0] SRC_RSVD = 2'd3;

    localparam logic [DIV_W-1:0] DIV_BY1 = 3'd0;
    localparam logic [DIV_W-1:0] DIV_BY8 = 3'd3;

    typedef struct packed {
        stop_st_e         st;
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
        logic             stop;
    } ctl_s;
endpackage

// File: rtl/stopw_irq_qual.sv
module stopw_irq_qual #(
    parameter int NUM_IRQ = 4,
    parameter int LVL_W   = 3
) (
    input  logic [NUM_IRQ-1:0]       irq_req_i,
    input  logic [NUM_IRQ*LVL_W-1:0] irq_lvl_i,
    input  logic [LVL_W-1:0]         cpu_lvl_i,
    input  logic                     ie_i,
    output logic                     wake_o
);
    logic [NUM_IRQ-1:0] hit;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        logic [LVL_W-1:0] lvl;
        assign lvl    = irq_lvl_i[i*LVL_W +: LVL_W];
        // level 0 means disabled; strict compare against processor level
        assign hit[i] = irq_req_i[i] && (lvl != '0) && (lvl > cpu_lvl_i);
    end

    assign wake_o = ie_i && (|hit);
endmodule

// File: rtl/stopw_stab_cnt.sv
module stopw_stab_cnt #(
    parameter int STAB_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic rdy_i,
    output logic done_o
);
    localparam int CNT_W = (STAB_CYC > 1) ? $clog2(STAB_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        done_o = 1'b0;
        if (!en_i || !rdy_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d  = '0;
            done_o = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/stopw_ctrl.sv
module stopw_ctrl
    import stopw_pkg::*;
#(
    parameter int NUM_IRQ  = 4,
    parameter int LVL_W    = 3,
    parameter int STAB_CYC = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr_i,
    input  logic [1:0]               cfg_src_i,
    input  logic [2:0]               cfg_div_i,
    input  logic                     stop_wr_i,
    input  logic                     stop_wdata_i,
    input  logic                     nmi_i,
    input  logic [NUM_IRQ-1:0]       irq_req_i,
    input  logic [NUM_IRQ*LVL_W-1:0] irq_lvl_i,
    input  logic [LVL_W-1:0]         cpu_lvl_i,
    input  logic                     ie_i,
    input  logic [2:0]               osc_rdy_i,
    output logic [2:0]               osc_en_o,
    output logic [1:0]               clk_src_o,
    output logic [2:0]               clk_div_o,
    output logic                     stop_bit_o,
    output logic                     cpu_clk_on_o
);
    localparam ctl_s CTL_RST = '{st: ST_WAKE, src: SRC_MAIN, div: DIV_BY8, stop: 1'b0};

    ctl_s ctl_d, ctl_q;
    logic irq_wake;
    logic sel_rdy;
    logic stab_done;
    logic [NUM_OSC-1:0] src_onehot;

    stopw_irq_qual #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W)) i_qual (
        .irq_req_i (irq_req_i),
        .irq_lvl_i (irq_lvl_i),
        .cpu_lvl_i (cpu_lvl_i),
        .ie_i      (ie_i),
        .wake_o    (irq_wake)
    );

    stopw_stab_cnt #(.STAB_CYC(STAB_CYC)) i_stab (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ctl_q.st == ST_WAKE),
        .rdy_i  (sel_rdy),
        .done_o (stab_done)
    );

    always_comb begin
        case (ctl_q.src)
            SRC_SUB: src_onehot = 3'b010;
            SRC_OCO: src_onehot = 3'b100;
            default: src_onehot = 3'b001;
        endcase
        sel_rdy = |(osc_rdy_i & src_onehot);
    end

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_RUN: begin
                if (cfg_wr_i && (cfg_src_i != SRC_RSVD)) begin
                    ctl_d.src = cfg_src_i;
                    ctl_d.div = cfg_div_i;
                end
                if (stop_wr_i && stop_wdata_i) begin
                    ctl_d.st   = ST_STOP;
                    ctl_d.stop = 1'b1;
                end
            end
            ST_STOP: begin
                if (nmi_i || irq_wake) begin
                    ctl_d.st   = ST_WAKE;
                    ctl_d.stop = 1'b0;
                    ctl_d.div  = (ctl_q.src == SRC_SUB) ? DIV_BY1 : DIV_BY8;
                end
            end
            ST_WAKE: begin
                if (stab_done) ctl_d.st = ST_RUN;
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign osc_en_o     = (ctl_q.st == ST_STOP) ? '0 : src_onehot;
    assign clk_src_o    = ctl_q.src;
    assign clk_div_o    = ctl_q.div;
    assign stop_bit_o   = ctl_q.stop;
    assign cpu_clk_on_o = (ctl_q.st == ST_RUN);

    // R2: entering stop closes the gate and drops every oscillator
    p_stop_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_bit_o) |-> (!cpu_clk_on_o && osc_en_o == 3'b000));

    // R5: nothing wakes a stop with no NMI and interrupts disabled
    p_stay_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_bit_o && !nmi_i && !ie_i) |=> stop_bit_o);

    // R6: an NMI wake on the sub clock runs undivided
    p_sub_undiv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_bit_o && nmi_i && clk_src_o == SRC_SUB) |=> (clk_div_o == DIV_BY1 && !stop_bit_o));

    // R8: the clock never turns on without the selected oscillator ready
    p_on_after_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_on_o) |-> $past(|(osc_rdy_i & osc_en_o)));

    // R9: the source cannot change outside the running state
    p_src_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_on_o |=> $stable(clk_src_o));
endmodule

// File: tb/test_stopw_ctrl.sv
`timescale 1ns/1ps
module test_stopw_ctrl;
    localparam int NUM_IRQ = 4;
    localparam int STAB    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_src = '0;
    logic [2:0]  cfg_div = '0;
    logic        stop_wr = 1'b0;
    logic        stop_wdata = 1'b0;
    logic        nmi = 1'b0;
    logic [3:0]  irq_req = '0;
    logic [11:0] irq_lvl = '0;
    logic [2:0]  cpu_lvl = '0;
    logic        ie = 1'b0;
    logic [2:0]  rdy_mask = 3'b111;
    logic [2:0]  osc_rdy, osc_en;
    logic [1:0]  clk_src;
    logic [2:0]  clk_div;
    logic        stop_bit, clk_on;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;
    assign osc_rdy = osc_en & rdy_mask;

    stopw_ctrl #(.NUM_IRQ(NUM_IRQ), .LVL_W(3), .STAB_CYC(STAB)) i_stopw_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_i(cfg_wr), .cfg_src_i(cfg_src), .cfg_div_i(cfg_div),
        .stop_wr_i(stop_wr), .stop_wdata_i(stop_wdata),
        .nmi_i(nmi), .irq_req_i(irq_req), .irq_lvl_i(irq_lvl),
        .cpu_lvl_i(cpu_lvl), .ie_i(ie), .osc_rdy_i(osc_rdy),
        .osc_en_o(osc_en), .clk_src_o(clk_src), .clk_div_o(clk_div),
        .stop_bit_o(stop_bit), .cpu_clk_on_o(clk_on)
    );

    // vector: req[21:18] lvl[17:6] cpu[5:3] ie[2] nmi[1] expect_wake[0]
    localparam logic [21:0] VEC [8] = '{
        {4'b0001, 12'h003, 3'd2, 1'b1, 1'b0, 1'b1},
        {4'b0001, 12'h002, 3'd2, 1'b1, 1'b0, 1'b0},
        {4'b0001, 12'h007, 3'd2, 1'b0, 1'b0, 1'b0},
        {4'b0010, 12'h000, 3'd0, 1'b1, 1'b0, 1'b0},
        {4'b1000, 12'h200, 3'd0, 1'b1, 1'b0, 1'b1},
        {4'b0000, 12'h000, 3'd0, 1'b0, 1'b1, 1'b1},
        {4'b0100, 12'h140, 3'd4, 1'b1, 1'b0, 1'b1},
        {4'b0000, 12'hFFF, 3'd0, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles_to_on(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!clk_on && n < 200);
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [2:0] d);
        cfg_wr = 1'b1; cfg_src = s; cfg_div = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic enter_stop();
        stop_wr = 1'b1; stop_wdata = 1'b1;
        @(negedge clk);
        stop_wr = 1'b0; stop_wdata = 1'b0;
    endtask

    task automatic nmi_pulse();
        nmi = 1'b1;
        @(negedge clk);
        nmi = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 src", clk_src, 0);
        check("R1 div", clk_div, 3);
        check("R1 stop", stop_bit, 0);
        check("R1 clk_on", clk_on, 0);
        check("R1 osc_en", osc_en, 1);
        cycles_to_on(n);
        check("R8 reset stabilisation", n, STAB);

        // vector table: R3 R4 R5
        foreach (VEC[k]) begin
            cfg_write(2'd0, 3'd0);
            enter_stop();
            @(negedge clk);
            check("R5 stays stopped", stop_bit, 1);
            irq_req = VEC[k][21:18];
            irq_lvl = VEC[k][17:6];
            cpu_lvl = VEC[k][5:3];
            ie      = VEC[k][2];
            nmi     = VEC[k][1];
            @(negedge clk);
            check(VEC[k][1] ? "R3 nmi wake" : "R4 irq qualify", !stop_bit, int'(VEC[k][0]));
            irq_req = '0; irq_lvl = '0; cpu_lvl = '0; ie = 1'b0; nmi = 1'b0;
            if (!VEC[k][0]) begin
                check("R5 clock off", clk_on, 0);
                nmi_pulse();
            end
            cycles_to_on(n);
        end

        // R2 stop write with data 0 ignored, data 1 gates
        stop_wr = 1'b1; stop_wdata = 1'b0;
        @(negedge clk);
        stop_wr = 1'b0;
        check("R2 write0 stop", stop_bit, 0);
        check("R2 write0 clk_on", clk_on, 1);
        enter_stop();
        check("R2 stop bit", stop_bit, 1);
        check("R2 clk off", clk_on, 0);
        check("R2 osc off", osc_en, 0);
        nmi_pulse();
        cycles_to_on(n);
        check("R8 wake stabilisation", n, STAB);

        // R9 config writes
        cfg_write(2'd1, 3'd2);
        check("R9 src", clk_src, 1);
        check("R9 div", clk_div, 2);
        cfg_write(2'd3, 3'd5);
        check("R9 rsvd src", clk_src, 1);
        check("R9 rsvd div", clk_div, 2);

        // R6 sub wake, with a config write while stopped ignored
        enter_stop();
        cfg_write(2'd2, 3'd4);
        check("R9 write in stop", clk_src, 1);
        nmi_pulse();
        check("R6 src", clk_src, 1);
        check("R6 div", clk_div, 0);
        check("R6 osc_en", osc_en, 2);
        cycles_to_on(n);

        // R7 on-chip wake; R8 ready held low then restored
        cfg_write(2'd2, 3'd0);
        enter_stop();
        rdy_mask = 3'b000;
        nmi_pulse();
        check("R7 div", clk_div, 3);
        check("R7 osc_en", osc_en, 4);
        repeat (20) @(negedge clk);
        check("R8 no ready", clk_on, 0);
        rdy_mask = 3'b111;
        repeat (8) @(negedge clk);
        rdy_mask = 3'b000;
        @(negedge clk);
        rdy_mask = 3'b111;
        cycles_to_on(n);
        check("R8 restart after drop", n, STAB);

        // R7 main wake via peripheral
        cfg_write(2'd0, 3'd1);
        enter_stop();
        irq_req = 4'b0001; irq_lvl = 12'h001; ie = 1'b1;
        @(negedge clk);
        irq_req = '0; irq_lvl = '0; ie = 1'b0;
        check("R7 main div", clk_div, 3);
        check("R7 main src", clk_src, 0);
        cycles_to_on(n);

        // R10 reset during stop
        cfg_write(2'd1, 3'd1);
        enter_stop();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R10 src", clk_src, 0);
        check("R10 div", clk_div, 3);
        check("R10 stop", stop_bit, 0);
        cycles_to_on(n);
        check("R10 restart", n, STAB);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule